// File: doc/BRIEF.md
# Coherent Pulse Integration Averager

This block sums repeated radar returns range bin by range bin over a run-time number of pulses, so that a later division by the pulse count gives a coherent average. Unsigned 8-bit samples arrive four to a transfer. Each range bin has one 32-bit accumulator, held in on-chip storage that is split into four lanes. A host-side acquire request starts an integration and latches the pulse count. After that, one PRF-aligned sync strobe per pulse opens the capture window for that pulse's record.

The block raises busy for the whole integration and drain. It flags completion with a one-cycle pulse when the final pulse's last transfer has been accumulated. It then streams the sums out in range order through a valid/ready port. Busy is released only after the host has taken the last word. Dividing by the count is left to software.

Top module: `pulse_integrator`

## Requirements
- R1: During and right after reset, `busy`, `int_done` and `out_valid` are low.
- R2: When idle, `acq_req` raises `busy` on the next cycle and latches `cfg_count`. An `acq_req` that arrives while `busy` is high is ignored: the count is not re-latched and the integration does not restart.
- R3: A `pulse_sync` that arrives while waiting for a pulse opens a capture of `REC_LEN/4` transfers. Only cycles with `in_valid` high count as transfers. Transfers offered outside a capture window leave the sums unchanged.
- R4: Byte k of `in_data` (bits 8k+7 down to 8k) is range sample 4*t+k of transfer t. The byte is treated as an unsigned value from 0 to 255.
- R5: On the first pulse of an integration, each accumulator is loaded with its sample. On later pulses the sample is added. No value from an earlier integration is left in the result.
- R6: The number of pulses integrated equals `cfg_count` for any value from 1 to 65535. A value of 0 is taken as 1.
- R7: `int_done` is high for exactly one cycle. That cycle is the one after the final pulse's last transfer is accepted, and `out_valid` is first high in that same cycle.
- R8: Results leave in range order, starting at sample 0. `out_last` is high only on sample `REC_LEN-1`. `out_data` and `out_valid` hold steady while `out_ready` is low.
- R9: `busy` falls on the cycle after the last word is accepted. An `acq_req` given in that acceptance cycle is ignored.
- R10: A `pulse_sync` that arrives during a capture or a drain has no effect.

Note: the 32-bit accumulator is wide enough by construction, since 65535 × 255 is below 2^24. The largest count is not exercised in the bench.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_req | input | 1 | Request to start an integration |
| cfg_count | input | 16 | Number of pulses to integrate (0 is taken as 1) |
| pulse_sync | input | 1 | PRF-aligned strobe that opens one pulse's capture |
| in_valid | input | 1 | Transfer on `in_data` is valid |
| in_data | input | 32 | Four unsigned 8-bit samples, lowest byte first in range |
| busy | output | 1 | Integration or drain in progress; acquire requests are ignored |
| int_done | output | 1 | One-cycle pulse when integration completes |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Downstream accepts the result word |
| out_data | output | 32 | Accumulated sum for the current range sample |
| out_last | output | 1 | Current word is the final range sample |

## Verification
Two events can coincide at the end of a run. The last word's acceptance and a new acquire request can fall in the same cycle. The bench provokes this by asserting `acq_req` exactly in the final ready cycle. It then judges that `busy` drops on the next cycle and stays low, which shows the request was ignored rather than queued (R9). A second collision can happen during capture: a stray `pulse_sync` may land in a gap between transfers. Here the bench compares every drained sum against its own model; a wrongly restarted capture would shift the transfer index and corrupt the sums (R10).

// File: rtl/pint_pkg.sv
package pint_pkg;
  parameter int unsigned SAMPLE_W = 8;
  parameter int unsigned GROUP    = 4;
  parameter int unsigned ACC_W    = 32;
  parameter int unsigned CNT_W    = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_CAPT, ST_DRAIN} pint_state_e;

  // Zero count behaves as a single pulse.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  // Load on the first pulse, add on later ones.
  function automatic logic [ACC_W-1:0] acc_next(input logic first,
                                                input logic [ACC_W-1:0] old,
                                                input logic [SAMPLE_W-1:0] s);
    return first ? ACC_W'(s) : old + ACC_W'(s);
  endfunction
endpackage

// File: rtl/pint_bank.sv
module pint_bank
  import pint_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                first,
  input  logic [AW-1:0]       waddr,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [AW-1:0]       raddr,
  output logic [ACC_W-1:0]    rdata
);
  logic [ACC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= acc_next(first, mem[waddr], sample);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pint_ctrl.sv
module pint_ctrl
  import pint_pkg::*;
#(
  parameter int unsigned REC_LEN = 1024,
  localparam int unsigned BEATS  = REC_LEN / GROUP,
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int unsigned IDX_W  = $clog2(REC_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_req,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              pulse_sync,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              cap_en,
  output logic              first_pulse,
  output logic [BEAT_W-1:0] beat_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              busy,
  output logic              int_done,
  output logic              out_valid,
  output logic              out_last
);
  pint_state_e       state_q;
  logic [CNT_W-1:0]  tgt_q, pulse_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IDX_W-1:0]  rd_q;
  logic              done_q;
  logic              last_beat, last_pulse, rd_last, done_evt;

  assign last_beat  = (beat_q == BEAT_W'(BEATS - 1));
  assign last_pulse = (pulse_q == tgt_q - CNT_W'(1));
  assign rd_last    = (rd_q == IDX_W'(REC_LEN - 1));
  assign cap_en     = (state_q == ST_CAPT) && in_valid;
  assign done_evt   = cap_en && last_beat && last_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= CNT_W'(1);
      pulse_q <= '0;
      beat_q  <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_evt;
      unique case (state_q)
        ST_IDLE: if (acq_req) begin
          tgt_q   <= eff_count(cfg_count);
          pulse_q <= '0;
          state_q <= ST_ARM;
        end
        ST_ARM: if (pulse_sync) begin
          beat_q  <= '0;
          state_q <= ST_CAPT;
        end
        ST_CAPT: if (in_valid) begin
          if (!last_beat) beat_q <= beat_q + BEAT_W'(1);
          else if (last_pulse) begin
            rd_q    <= '0;
            state_q <= ST_DRAIN;
          end else begin
            pulse_q <= pulse_q + CNT_W'(1);
            state_q <= ST_ARM;
          end
        end
        ST_DRAIN: if (out_ready) begin
          if (rd_last) state_q <= ST_IDLE;
          else rd_q <= rd_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign first_pulse = (pulse_q == '0);
  assign beat_idx    = beat_q;
  assign rd_idx      = rd_q;
  assign busy        = (state_q != ST_IDLE);
  assign int_done    = done_q;
  assign out_valid   = (state_q == ST_DRAIN);
  assign out_last    = out_valid && rd_last;
endmodule

// File: rtl/pulse_integrator.sv
module pulse_integrator
  import pint_pkg::*;
#(
  parameter int unsigned REC_LEN = 1024,
  localparam int unsigned BEATS  = REC_LEN / GROUP,
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int unsigned IDX_W  = $clog2(REC_LEN),
  localparam int unsigned LANE_W = $clog2(GROUP),
  localparam int unsigned IN_W   = GROUP * SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_req,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             pulse_sync,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             busy,
  output logic             int_done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  output logic             out_last
);
  logic              cap_en, first_pulse;
  logic [BEAT_W-1:0] beat_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [ACC_W-1:0]  bank_rd [GROUP];

  pint_ctrl #(.REC_LEN(REC_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .cfg_count(cfg_count),
    .pulse_sync(pulse_sync), .in_valid(in_valid), .out_ready(out_ready),
    .cap_en(cap_en), .first_pulse(first_pulse), .beat_idx(beat_idx),
    .rd_idx(rd_idx), .busy(busy), .int_done(int_done),
    .out_valid(out_valid), .out_last(out_last)
  );

  for (genvar g = 0; g < GROUP; g++) begin : g_lane
    pint_bank #(.DEPTH(BEATS)) u_bank (
      .clk(clk), .wr_en(cap_en), .first(first_pulse), .waddr(beat_idx),
      .sample(in_data[g*SAMPLE_W +: SAMPLE_W]),
      .raddr(rd_idx[IDX_W-1:LANE_W]), .rdata(bank_rd[g])
    );
  end

  assign out_data = bank_rd[rd_idx[LANE_W-1:0]];
endmodule

// File: rtl/pulse_integrator_chk.sv
module pulse_integrator_chk
  import pint_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             acq_req,
  input logic             cap_en,
  input logic             busy,
  input logic             int_done,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data,
  input logic             out_last
);
  // R2
  acq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && acq_req) |=> busy);
  // R3
  capture_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (busy && !out_valid));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_done |=> !int_done);
  // R7
  done_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_done |-> (out_valid && !$past(out_valid)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !busy);
  // R9
  fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready && out_last));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !int_done));
endmodule

bind pulse_integrator pulse_integrator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .cap_en(cap_en),
  .busy(busy), .int_done(int_done), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/pulse_integrator_bench.sv
`timescale 1ns/1ps
module pulse_integrator_bench;
  localparam int REC = 32;
  localparam int G   = 4;
  localparam int NB  = REC / G;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acq_req = 1'b0;
  logic [15:0] cfg_count = '0;
  logic        pulse_sync = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        busy, int_done, out_valid, out_last;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  longint exp_sum [REC];

  always #5 clk = ~clk;

  pulse_integrator #(.REC_LEN(REC)) u_pulse_integrator (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .cfg_count(cfg_count),
    .pulse_sync(pulse_sync), .in_valid(in_valid), .in_data(in_data),
    .busy(busy), .int_done(int_done), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Sample value: mode 0 random, 1 all 255, 2 ramp by range index.
  function automatic logic [7:0] pick(input int mode, input int p, input int idx);
    if (mode == 1) return 8'hFF;
    if (mode == 2) return 8'((idx * 3 + p) & 255);
    return 8'($urandom);
  endfunction

  task automatic one_pulse(input int p, input bit is_last, input int mode);
    // R3: transfers offered before the sync are ignored
    in_valid = 1'b1; in_data = $urandom;
    @(negedge clk);
    in_data = $urandom;
    @(negedge clk);
    in_valid = 1'b0; pulse_sync = 1'b1;
    @(negedge clk);
    pulse_sync = 1'b0;
    for (int t = 0; t < NB; t++) begin
      if ($urandom % 3 == 0) begin
        in_valid = 1'b0; in_data = $urandom;
        pulse_sync = ($urandom % 2 == 0); // R10: stray sync mid-capture
        @(negedge clk);
        pulse_sync = 1'b0;
      end
      in_valid = 1'b1;
      for (int k = 0; k < G; k++) begin
        logic [7:0] s;
        s = pick(mode, p, t * G + k);
        in_data[k*8 +: 8] = s; // R4: byte k is sample 4t+k
        exp_sum[t*G+k] = (p == 0) ? longint'(s) : exp_sum[t*G+k] + longint'(s);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(int_done == is_last, "R7", "int_done after pulse", int_done, is_last);
    chk(out_valid == is_last, "R7", "out_valid with done", out_valid, is_last);
    chk(busy == 1'b1, "R6", "busy between pulses", busy, 1);
  endtask

  task automatic drain(input bit acq_at_end);
    int idx = 0;
    int cyc = 0;
    bit rdy;
    while (idx < REC) begin
      if (cyc == 1) chk(int_done == 1'b0, "R7", "int_done width", int_done, 0);
      chk(out_valid == 1'b1, "R8", "out_valid in drain", out_valid, 1);
      chk(longint'(out_data) == exp_sum[idx], "R5", $sformatf("sum[%0d]", idx),
          out_data, exp_sum[idx]);
      chk(out_last == (idx == REC - 1), "R8", "out_last", out_last, idx == REC - 1);
      rdy = ($urandom % 3 != 0);
      out_ready = rdy;
      pulse_sync = ($urandom % 5 == 0); // R10
      acq_req = acq_at_end && rdy && (idx == REC - 1);
      cfg_count = 16'd9;
      @(negedge clk);
      acq_req = 1'b0; pulse_sync = 1'b0;
      if (rdy) idx++;
      cyc++;
    end
    out_ready = 1'b0;
    chk(busy == 1'b0, "R9", "busy after last accept", busy, 0);
    chk(out_valid == 1'b0, "R9", "out_valid after drain", out_valid, 0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R9", "acq in final cycle ignored", busy, 0);
  endtask

  task automatic integrate(input int cfg, input int pulses, input int mode,
                           input bit poke, input bit acq_at_end);
    chk(busy == 1'b0, "R2", "idle before start", busy, 0);
    acq_req = 1'b1; cfg_count = 16'(cfg);
    @(negedge clk);
    acq_req = 1'b0; cfg_count = 16'hFFFF;
    chk(busy == 1'b1, "R2", "busy after acq", busy, 1);
    for (int p = 0; p < pulses; p++) begin
      one_pulse(p, p == pulses - 1, mode);
      if (poke && p == 0 && pulses > 1) begin
        acq_req = 1'b1; cfg_count = 16'd7; // R2: ignored while busy
        @(negedge clk);
        acq_req = 1'b0;
      end
    end
    drain(acq_at_end);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20011029));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int_done == 1'b0, "R1", "int_done after reset", int_done, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);

    integrate(1, 1, 0, 1'b0, 1'b1);  // R6 minimum count, R9 collision
    integrate(3, 3, 0, 1'b1, 1'b0);  // R2 ignored re-request
    integrate(0, 1, 2, 1'b0, 1'b0);  // R6 zero as one, R4 ramp order
    integrate(4, 4, 1, 1'b0, 1'b1);  // full-scale samples
    integrate(2, 2, 2, 1'b1, 1'b0);  // R5 no leftover from before
    for (int r = 0; r < 3; r++) integrate(r + 2, r + 2, 0, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule